// File: doc/BRIEF.md
# Speculative Register Rename Unit

This unit sits at the front of an out-of-order core. It gives every register-writing instruction a fresh physical register drawn from a pool that is larger than the architectural register set. Each cycle one instruction may be renamed: its two source register numbers are translated through the speculative map, and its destination, if any, receives a new physical tag. That tag stays speculative until the instruction retires through the in-order commit port.

Commit does only two things. It makes the new mapping part of the committed map, and it returns to the free pool the physical register that held the previous value of the same architectural register. Registers are never reclaimed when a value is produced or last read. A flush throws away all speculative work: the speculative map is restored from the committed map, and every tag that in-flight writers held goes back to the pool. A read port returns the committed physical location of any architectural register, so the architectural state can be located once the pipeline has drained.

The default pool has 32 architectural and 64 physical registers (6-bit tags). Register 0 is hardwired and is never renamed.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i in both maps, rd_phys returns i for each i, and ren_ready is high.
- R2: A rename accepted in cycle t (ren_valid and ren_ready high) shows ren_out_valid high in cycle t+1, with each source tag taken from the speculative map before this instruction's own destination is applied. A source equal to the destination therefore gets the older tag. With no accepted rename, ren_out_valid is low in t+1.
- R3: An accepted rename with a destination takes the oldest tag on the free list. After reset the free list holds 32 to 63 in ascending order, and tags released by commit join its tail in commit order.
- R4: A rename with ren_has_dst low, or with destination 0, allocates no tag (ren_pdst_valid low) and creates no in-flight entry. Source register 0 always returns tag 0.
- R5: ren_ready is low exactly when flush is high or no free tag remains. After 32 in-flight writers, renames stall and are ignored.
- R6: commit_valid with at least one in-flight writer retires the oldest one. One cycle later cm_valid is high, cm_arch and cm_ptag give its destination and new tag, and the committed map points that register at the new tag.
- R7: The tag released by a commit (cm_freed) is the one that the same architectural register was mapped to just before that writer was renamed.
- R8: commit_valid with no in-flight writer is ignored: cm_valid stays low and no map changes.
- R9: A flush copies the committed map into the speculative map and discards all in-flight writers. The rename input is not accepted in the flush cycle.
- R10: After a flush the free list is full again. The tags of discarded writers are handed out first, oldest writer first, followed by the tags that were already free.
- R11: A commit in the same cycle as a flush takes effect before the flush, so its mapping survives in the committed map.
- R12: rd_phys, one cycle after rd_arch is presented, gives the committed map entry for that register as it stood before that cycle's commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | Rename request |
| ren_src1 | input | 5 | First source architectural register |
| ren_src2 | input | 5 | Second source architectural register |
| ren_has_dst | input | 1 | Instruction writes a register |
| ren_dst | input | 5 | Destination architectural register |
| ren_ready | output | 1 | Rename can be accepted this cycle |
| ren_out_valid | output | 1 | Registered rename result valid |
| ren_psrc1 | output | 6 | Physical tag of first source |
| ren_psrc2 | output | 6 | Physical tag of second source |
| ren_pdst_valid | output | 1 | A destination tag was allocated |
| ren_pdst | output | 6 | Allocated destination tag |
| commit_valid | input | 1 | Retire the oldest in-flight writer |
| cm_valid | output | 1 | A commit took place in the previous cycle |
| cm_arch | output | 5 | Destination register of the retired writer |
| cm_ptag | output | 6 | Tag now committed for that register |
| cm_freed | output | 6 | Tag returned to the free list |
| flush | input | 1 | Discard all speculative state |
| rd_arch | input | 5 | Committed-map read address |
| rd_phys | output | 6 | Committed physical tag, one cycle later |

## Verification
The hardest state to reach is a flush that arrives while the free list has wrapped around its storage and many writers are in flight, possibly in the same cycle as a commit. The order in which tags come back then depends on the ring position left by earlier allocations and releases. The stimulus first fills the pool to a stall, then drains and refills it partly, then issues flushes on their own and together with commits. After that comes a long random phase with bursts of renames, commits and rare flushes. A queue-based model predicts every tag and every committed mapping, and its output is compared on every clock.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int RN_ARCH_DEF = 32;
  localparam int RN_PHYS_DEF = 64;
endpackage

// File: rtl/rn_map_table.sv
// Speculative and committed architectural-to-physical maps.
module rn_map_table #(
  parameter int ARCH = 32,
  parameter int AW   = 5,
  parameter int PW   = 6
)(
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] src1_a,
  input  logic [AW-1:0] src2_a,
  input  logic [AW-1:0] dst_a,
  output logic [PW-1:0] src1_t,
  output logic [PW-1:0] src2_t,
  output logic [PW-1:0] dst_old_t,
  input  logic          spec_we,
  input  logic [AW-1:0] spec_a,
  input  logic [PW-1:0] spec_t,
  input  logic          cm_we,
  input  logic [AW-1:0] cm_a,
  input  logic [PW-1:0] cm_t,
  input  logic          flush,
  input  logic [AW-1:0] cm_rd_a,
  output logic [PW-1:0] cm_rd_t
);
  logic [PW-1:0] spec_map [ARCH];
  logic [PW-1:0] comm_map [ARCH];
  logic [PW-1:0] comm_nxt [ARCH];

  assign src1_t    = spec_map[src1_a];
  assign src2_t    = spec_map[src2_a];
  assign dst_old_t = spec_map[dst_a];
  assign cm_rd_t   = comm_map[cm_rd_a];

  // Commit is applied before a same-cycle flush copies the map back.
  always_comb begin
    comm_nxt = comm_map;
    if (cm_we) comm_nxt[cm_a] = cm_t;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ARCH; i++) begin
        spec_map[i] <= PW'(i);
        comm_map[i] <= PW'(i);
      end
    end else begin
      comm_map <= comm_nxt;
      if (flush)        spec_map <= comm_nxt;
      else if (spec_we) spec_map[spec_a] <= spec_t;
    end
  end
endmodule

// File: rtl/rn_free_list.sv
// Ring of free physical tags. Allocation pops at head, release pushes at
// tail. Tags held by in-flight writers stay in the slots just behind head,
// so a flush only has to move head back to the tail.
module rn_free_list #(
  parameter int DEPTH = 32,
  parameter int BASE  = 32,
  parameter int PW    = 6,
  localparam int XW   = $clog2(DEPTH)
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc,
  output logic [PW-1:0] head_tag,
  input  logic          rel,
  input  logic [PW-1:0] rel_tag,
  input  logic          rewind,
  output logic [XW:0]   count
);
  logic [PW-1:0] ring [DEPTH];
  logic [XW-1:0] head, tail;

  assign head_tag = ring[head];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ring[i] <= PW'(BASE + i);
      head  <= '0;
      tail  <= '0;
      count <= (XW+1)'(DEPTH);
    end else begin
      if (rel) begin
        ring[tail] <= rel_tag;
        tail       <= tail + XW'(1);
      end
      if (rewind) begin
        head  <= tail + XW'(rel);
        count <= (XW+1)'(DEPTH);
      end else begin
        head  <= head + XW'(alloc);
        count <= count + (XW+1)'(rel) - (XW+1)'(alloc);
      end
    end
  end
endmodule

// File: rtl/rn_hist_fifo.sv
// In-order record of writers: {dst arch, new tag, previous tag}.
module rn_hist_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 17,
  localparam int XW   = $clog2(DEPTH)
)(
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  input  logic         clear,
  output logic [W-1:0] head_data,
  output logic [XW:0]  count
);
  logic [W-1:0]  mem [DEPTH];
  logic [XW-1:0] wr_ptr, rd_ptr;

  assign head_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr + XW'(push);
      if (clear) begin
        rd_ptr <= wr_ptr + XW'(push);
        count  <= '0;
      end else begin
        rd_ptr <= rd_ptr + XW'(pop);
        count  <= count + (XW+1)'(push) - (XW+1)'(pop);
      end
    end
  end
endmodule

// File: rtl/rename_unit.sv
module rename_unit
  import rn_pkg::*;
#(
  parameter int ARCH_REGS = RN_ARCH_DEF,
  parameter int PHYS_REGS = RN_PHYS_DEF,
  localparam int AW    = $clog2(ARCH_REGS),
  localparam int PW    = $clog2(PHYS_REGS),
  localparam int EXTRA = PHYS_REGS - ARCH_REGS,
  localparam int XW    = $clog2(EXTRA)
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          ren_valid,
  input  logic [AW-1:0] ren_src1,
  input  logic [AW-1:0] ren_src2,
  input  logic          ren_has_dst,
  input  logic [AW-1:0] ren_dst,
  output logic          ren_ready,
  output logic          ren_out_valid,
  output logic [PW-1:0] ren_psrc1,
  output logic [PW-1:0] ren_psrc2,
  output logic          ren_pdst_valid,
  output logic [PW-1:0] ren_pdst,
  input  logic          commit_valid,
  output logic          cm_valid,
  output logic [AW-1:0] cm_arch,
  output logic [PW-1:0] cm_ptag,
  output logic [PW-1:0] cm_freed,
  input  logic          flush,
  input  logic [AW-1:0] rd_arch,
  output logic [PW-1:0] rd_phys
);
  localparam int HW = AW + 2*PW;

  logic [XW:0]   fl_count, hist_count;
  logic [PW-1:0] fl_head;
  logic [PW-1:0] sp_s1, sp_s2, sp_old, cm_rd;
  logic [HW-1:0] hist_head;
  logic [AW-1:0] h_dst;
  logic [PW-1:0] h_new, h_old;
  logic          ren_fire, do_alloc, do_commit;

  assign ren_ready = !flush && (fl_count != '0);
  assign ren_fire  = ren_valid && ren_ready;
  assign do_alloc  = ren_fire && ren_has_dst && (ren_dst != '0);
  assign do_commit = commit_valid && (hist_count != '0);
  assign {h_dst, h_new, h_old} = hist_head;

  rn_map_table #(.ARCH(ARCH_REGS), .AW(AW), .PW(PW)) u_map (
    .clk(clk), .rst(rst),
    .src1_a(ren_src1), .src2_a(ren_src2), .dst_a(ren_dst),
    .src1_t(sp_s1), .src2_t(sp_s2), .dst_old_t(sp_old),
    .spec_we(do_alloc), .spec_a(ren_dst), .spec_t(fl_head),
    .cm_we(do_commit), .cm_a(h_dst), .cm_t(h_new),
    .flush(flush), .cm_rd_a(rd_arch), .cm_rd_t(cm_rd)
  );

  rn_free_list #(.DEPTH(EXTRA), .BASE(ARCH_REGS), .PW(PW)) u_free (
    .clk(clk), .rst(rst),
    .alloc(do_alloc), .head_tag(fl_head),
    .rel(do_commit), .rel_tag(h_old),
    .rewind(flush), .count(fl_count)
  );

  rn_hist_fifo #(.DEPTH(EXTRA), .W(HW)) u_hist (
    .clk(clk), .rst(rst),
    .push(do_alloc), .push_data({ren_dst, fl_head, sp_old}),
    .pop(do_commit), .clear(flush),
    .head_data(hist_head), .count(hist_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ren_out_valid  <= 1'b0;
      ren_psrc1      <= '0;
      ren_psrc2      <= '0;
      ren_pdst_valid <= 1'b0;
      ren_pdst       <= '0;
      cm_valid       <= 1'b0;
      cm_arch        <= '0;
      cm_ptag        <= '0;
      cm_freed       <= '0;
      rd_phys        <= '0;
    end else begin
      ren_out_valid  <= ren_fire;
      ren_pdst_valid <= do_alloc;
      if (ren_fire) begin
        ren_psrc1 <= sp_s1;
        ren_psrc2 <= sp_s2;
      end
      if (do_alloc) ren_pdst <= fl_head;
      cm_valid <= do_commit;
      if (do_commit) begin
        cm_arch  <= h_dst;
        cm_ptag  <= h_new;
        cm_freed <= h_old;
      end
      rd_phys <= cm_rd;
    end
  end
endmodule

// File: rtl/rename_unit_chk.sv
module rename_unit_chk #(
  parameter int AW    = 5,
  parameter int XW    = 5,
  parameter int EXTRA = 32
)(
  input logic          clk,
  input logic          rst,
  input logic          flush,
  input logic          commit_valid,
  input logic          ren_valid,
  input logic          ren_ready,
  input logic          ren_has_dst,
  input logic [AW-1:0] ren_dst,
  input logic          ren_out_valid,
  input logic          ren_pdst_valid,
  input logic          cm_valid,
  input logic [XW:0]   fl_count,
  input logic [XW:0]   hist_count
);
  // R5: free tags plus in-flight writers always account for the extra pool
  a_r5_pool_balance: assert property (@(posedge clk) disable iff (rst)
    (int'(fl_count) + int'(hist_count)) == EXTRA);

  a_r2_out_follows_fire: assert property (@(posedge clk) disable iff (rst)
    (ren_valid && ren_ready) |=> ren_out_valid);

  a_r2_out_idle: assert property (@(posedge clk) disable iff (rst)
    !(ren_valid && ren_ready) |=> !ren_out_valid);

  a_r4_no_alloc: assert property (@(posedge clk) disable iff (rst)
    (ren_valid && ren_ready && (!ren_has_dst || ren_dst == '0)) |=> !ren_pdst_valid);

  a_r6_commit_reports: assert property (@(posedge clk) disable iff (rst)
    (commit_valid && hist_count != '0) |=> cm_valid);

  a_r8_empty_commit: assert property (@(posedge clk) disable iff (rst)
    (commit_valid && hist_count == '0) |=> !cm_valid);

  a_r10_flush_refill: assert property (@(posedge clk) disable iff (rst)
    flush |=> (int'(fl_count) == EXTRA && hist_count == '0));
endmodule

bind rename_unit rename_unit_chk #(.AW(AW), .XW(XW), .EXTRA(EXTRA)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .commit_valid(commit_valid),
  .ren_valid(ren_valid), .ren_ready(ren_ready), .ren_has_dst(ren_has_dst),
  .ren_dst(ren_dst), .ren_out_valid(ren_out_valid),
  .ren_pdst_valid(ren_pdst_valid), .cm_valid(cm_valid),
  .fl_count(fl_count), .hist_count(hist_count)
);

// File: tb/rename_unit_bench.sv
module rename_unit_bench;
  localparam int A = 32;
  localparam int P = 64;

  logic clk = 1'b0;
  logic rst;
  always #10 clk = ~clk;

  logic       ren_valid, ren_has_dst, commit_valid, flush;
  logic [4:0] ren_src1, ren_src2, ren_dst, rd_arch;
  logic       ren_ready, ren_out_valid, ren_pdst_valid, cm_valid;
  logic [5:0] ren_psrc1, ren_psrc2, ren_pdst, cm_ptag, cm_freed, rd_phys;
  logic [4:0] cm_arch;

  rename_unit u_rename_unit (
    .clk(clk), .rst(rst),
    .ren_valid(ren_valid), .ren_src1(ren_src1), .ren_src2(ren_src2),
    .ren_has_dst(ren_has_dst), .ren_dst(ren_dst), .ren_ready(ren_ready),
    .ren_out_valid(ren_out_valid), .ren_psrc1(ren_psrc1), .ren_psrc2(ren_psrc2),
    .ren_pdst_valid(ren_pdst_valid), .ren_pdst(ren_pdst),
    .commit_valid(commit_valid), .cm_valid(cm_valid), .cm_arch(cm_arch),
    .cm_ptag(cm_ptag), .cm_freed(cm_freed),
    .flush(flush), .rd_arch(rd_arch), .rd_phys(rd_phys)
  );

  int n_chk = 0;
  int n_err = 0;

  // Behavioural model
  int spec[A];
  int comm[A];
  int fq[$];
  int hd[$];
  int hn[$];
  int ho[$];

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input bit rv, input int s1, input int s2, input bit hdst,
                     input int d, input bit cv, input bit fl, input int ra);
    bit rdy, fire, e_pv, e_cm;
    int e_s1, e_s2, e_pd, e_rd, ecd, ecn, eco;
    ren_valid = rv; ren_src1 = 5'(s1); ren_src2 = 5'(s2);
    ren_has_dst = hdst; ren_dst = 5'(d);
    commit_valid = cv; flush = fl; rd_arch = 5'(ra);
    #1;
    rdy = !fl && (fq.size() > 0);
    chk("R5", "ren_ready", 32'(ren_ready), 32'(rdy));
    fire = rv && rdy;
    e_rd = comm[ra];
    e_cm = cv && (hn.size() > 0);
    e_pv = 1'b0; e_s1 = 0; e_s2 = 0; e_pd = 0; ecd = 0; ecn = 0; eco = 0;
    if (e_cm) begin
      ecd = hd.pop_front(); ecn = hn.pop_front(); eco = ho.pop_front();
      comm[ecd] = ecn;
      fq.push_back(eco);
    end
    if (fire) begin
      e_s1 = spec[s1]; e_s2 = spec[s2];
      e_pv = hdst && (d != 0);
      if (e_pv) begin
        e_pd = fq.pop_front();
        hd.push_back(d); hn.push_back(e_pd); ho.push_back(spec[d]);
        spec[d] = e_pd;
      end
    end
    if (fl) begin
      for (int i = 0; i < A; i++) spec[i] = comm[i];
      fq = {hn, fq};
      hd.delete(); hn.delete(); ho.delete();
    end
    @(posedge clk);
    @(negedge clk);
    chk("R2", "ren_out_valid", 32'(ren_out_valid), 32'(fire));
    if (fire) begin
      chk("R2", "ren_psrc1", 32'(ren_psrc1), 32'(e_s1));
      chk("R2", "ren_psrc2", 32'(ren_psrc2), 32'(e_s2));
      chk("R4", "ren_pdst_valid", 32'(ren_pdst_valid), 32'(e_pv));
      if (e_pv) chk("R3", "ren_pdst", 32'(ren_pdst), 32'(e_pd));
    end
    chk(e_cm ? "R6" : "R8", "cm_valid", 32'(cm_valid), 32'(e_cm));
    if (e_cm) begin
      chk("R6", "cm_arch", 32'(cm_arch), 32'(ecd));
      chk("R6", "cm_ptag", 32'(cm_ptag), 32'(ecn));
      chk("R7", "cm_freed", 32'(cm_freed), 32'(eco));
    end
    chk("R12", "rd_phys", 32'(rd_phys), 32'(e_rd));
  endtask

  task automatic idle(input int ra);
    cyc(0, 0, 0, 0, 0, 0, 0, ra);
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int x, saved, first_disc;
    rst = 1'b1;
    ren_valid = 0; ren_src1 = 0; ren_src2 = 0; ren_has_dst = 0; ren_dst = 0;
    commit_valid = 0; flush = 0; rd_arch = 0;
    for (int i = 0; i < A; i++) begin spec[i] = i; comm[i] = i; end
    for (int i = A; i < P; i++) fq.push_back(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1", "ren_ready after reset", 32'(ren_ready), 32'd1);
    chk("R1", "ren_out_valid after reset", 32'(ren_out_valid), 32'd0);

    // R1: identity committed map
    for (int i = 0; i < A; i++) begin
      idle(i);
      chk("R1", "identity map", 32'(rd_phys), 32'(i));
    end

    // R2: source equal to destination sees the older tag
    cyc(1, 1, 1, 1, 1, 0, 0, 0);
    chk("R2", "src==dst old tag", 32'(ren_psrc1), 32'd1);
    chk("R3", "first alloc", 32'(ren_pdst), 32'd32);
    cyc(1, 1, 2, 1, 3, 0, 0, 0);
    chk("R2", "src sees new mapping", 32'(ren_psrc1), 32'd32);
    // R4: no destination, destination zero, source zero
    cyc(1, 0, 5, 0, 7, 0, 0, 0);
    chk("R4", "no dst alloc", 32'(ren_pdst_valid), 32'd0);
    chk("R4", "src zero", 32'(ren_psrc1), 32'd0);
    cyc(1, 0, 0, 1, 0, 0, 0, 0);
    chk("R4", "dst zero alloc", 32'(ren_pdst_valid), 32'd0);
    cyc(1, 4, 4, 1, 4, 0, 0, 0);
    chk("R4", "next tag unchanged", 32'(ren_pdst), 32'd34);

    // R5: fill the pool until stall
    x = 0;
    while (fq.size() > 0) begin
      cyc(1, x % A, (x + 7) % A, 1, (x % 31) + 1, 0, 0, 0);
      x++;
    end
    cyc(1, 3, 3, 1, 9, 0, 0, 0);
    chk("R5", "stalled rename ignored", 32'(ren_out_valid), 32'd0);

    // R6/R7: drain, then R8 extra commits
    while (hn.size() > 0) cyc(0, 0, 0, 0, 0, 1, 0, hd.size() > 0 ? hd[0] : 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 1);
    chk("R8", "empty commit ignored", 32'(cm_valid), 32'd0);
    idle(1);
    chk("R8", "map unchanged", 32'(rd_phys), 32'(comm[1]));

    // R9/R10: rename, partial commit, flush
    for (int i = 0; i < 6; i++) cyc(1, i, i + 1, 1, 10 + i, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 0, 0);
    first_disc = hn[0];
    cyc(1, 1, 1, 1, 20, 0, 1, 0);
    chk("R9", "rename in flush cycle ignored", 32'(ren_out_valid), 32'd0);
    saved = comm[13];
    cyc(1, 13, 14, 1, 21, 0, 0, 0);
    chk("R9", "spec map restored", 32'(ren_psrc1), 32'(saved));
    chk("R10", "discarded tag reused first", 32'(ren_pdst), 32'(first_disc));

    // R11: commit and flush in the same cycle
    for (int i = 0; i < 3; i++) cyc(1, 2, 3, 1, 25 + i, 0, 0, 0);
    saved = hn[0];
    x = hd[0];
    cyc(0, 0, 0, 0, 0, 1, 1, 0);
    idle(x);
    chk("R11", "commit kept across flush", 32'(rd_phys), 32'(saved));

    // Random mixed traffic
    for (int k = 0; k < 4000; k++) begin
      cyc(($urandom % 10) < 7, $urandom % A, $urandom % A,
          ($urandom % 20) < 17, $urandom % A,
          ($urandom % 10) < 4, ($urandom % 100) < 2, $urandom % A);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule